// File: doc/BRIEF.md
# NCO Phase Accumulator Controller

This block is the control front end of a direct digital synthesiser. Each clock it may capture a 34-bit command word. The capture happens only while the active-low clock enable is low. The block then decodes the word according to a mode input and a jump strobe. The word can act in one of four ways:

- a full phase increment;
- an absolute phase that overwrites the accumulator;
- a split word that carries a 16-bit amplitude and the upper 18 increment bits;
- a full increment load used in the amplitude mode.

A 34-bit phase accumulator adds the increment register on every clock and wraps modulo 2^34.

The block sends three values downstream on the same cycle: the top 16 accumulator bits as a phase word, the 16-bit amplitude, and a flag that enables amplitude modulation. All three stem from the same command word. A valid flag travels beside them, delayed by the same number of cycles. Sine and cosine generation and the output multipliers are in a separate block.

The output side is a free-running stream. The valid flag marks each output beat, and there is no ready signal and no back-pressure. The downstream stage must accept one beat on every clock. A beat that is not taken is replaced by the next one.

Top module: `nco_phase_ctrl`

## Requirements
- R1: A command word is captured on a rising edge only while `cen` is low. While `cen` is high the captured word is held and changes on `din` have no effect on any output.
- R2: The accumulator adds the increment register once per clock and wraps modulo 2^34. With an increment of 0x3_0000_0000 the phase output steps 0x0000, 0xC000, 0x8000, 0x4000, 0x0000.
- R3: A word captured with `mode`=0 and `jump`=0 replaces all 34 bits of the increment register.
- R4: A word captured with `mode`=0 and `jump`=1 replaces the accumulator value as an absolute phase, and the increment register is left unchanged. Writing 0x2_0000_0000 gives a phase output of 0x8000, which is half a turn.
- R5: A word captured with `mode`=1 and `jump`=0 behaves as follows. `din[17:0]` loads increment bits 33:16. Increment bits 15:0 keep their previous value: zero after reset, or the value of the last full load. `din[33:18]` becomes the two's complement amplitude.
- R6: A word captured with `mode`=1 and `jump`=1 loads all 34 increment bits and leaves the amplitude unchanged.
- R7: The `jump` input has an effect only when it arrives together with a captured word, that is with `cen` low. A `jump` that is high while `cen` is high is ignored.
- R8: A high level on `res` at a rising edge clears the accumulator, the increment register, the amplitude, the modulation flag, the output pipeline and the valid flag.
- R9: The phase output is accumulator bits 33:18. A word captured at edge 0 appears at the outputs after edge 1+OUT_STAGES, which is edge 2 by default.
- R10: The amplitude and `am_en_o` leave on the same cycle as the phase that follows from the same word. `am_en_o` equals the `mode` value of the last captured word. A word captured with `mode`=0 leaves the amplitude unchanged.
- R11: `vout` equals `vin` delayed by OUT_STAGES+2 clocks, which is 3 by default. The `vin` input has no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| res | input | 1 | Synchronous clear, active high |
| cen | input | 1 | Capture enable for the command word, active low |
| mode | input | 1 | 0: increment or absolute phase; 1: amplitude plus increment |
| jump | input | 1 | Selects the alternate meaning of the captured word |
| din | input | 34 | Command word |
| vin | input | 1 | Valid flag travelling with the stream |
| phase_o | output | 16 | Phase word, accumulator bits 33:18 |
| amp_o | output | 16 | Two's complement amplitude aligned to the phase word |
| am_en_o | output | 1 | Amplitude modulation enable aligned to the phase word |
| vout | output | 1 | Delayed valid flag |

## Verification
The bench steers a 34-bit full increment so that only bit 15 is set, then sends a split word. A design that dropped the kept low increment bits would let the phase fall one step short after about a dozen cycles. Absolute jumps are checked at the exact cycle they appear. A jump that is offered with `cen` high must leave the phase ramp intact, and a design that let it through would skip ahead. Further checks cover the following:
- The increment wraps through the full circle.
- `din` changes while the input is held.
- A mid-run clear must also zero the increment; leaving it would make the phase keep climbing.
- A single `vin` pulse must emerge on exactly the third edge.

// File: rtl/nco_pkg.sv
package nco_pkg;

  localparam int ACC_W    = 34;
  localparam int PHASE_W  = 16;
  localparam int AMP_W    = 16;
  localparam int COARSE_W = ACC_W - AMP_W;
  localparam int FINE_W   = ACC_W - COARSE_W;

  typedef struct packed {
    logic             load;
    logic             jump;
    logic             mode;
    logic [ACC_W-1:0] word;
  } nco_cmd_t;

  typedef struct packed {
    logic abs_jump;
    logic inc_full;
    logic inc_coarse;
    logic load;
    logic mode;
  } nco_ctl_t;

  typedef struct packed {
    logic [PHASE_W-1:0] phase;
    logic [AMP_W-1:0]   amp;
    logic               am_en;
  } nco_out_t;

endpackage

// File: rtl/nco_capture.sv
module nco_capture
  import nco_pkg::*;
(
  input  logic             clk,
  input  logic             res,
  input  logic             cen,
  input  logic             mode,
  input  logic             jump,
  input  logic [ACC_W-1:0] din,
  output nco_cmd_t         cmd_q
);

  always_ff @(posedge clk) begin
    if (res) begin
      cmd_q <= '0;
    end else begin
      cmd_q.load <= ~cen;
      if (!cen) begin
        cmd_q.word <= din;
        cmd_q.jump <= jump;
        cmd_q.mode <= mode;
      end else begin
        cmd_q.jump <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/nco_incr_reg.sv
module nco_incr_reg
  import nco_pkg::*;
(
  input  logic             clk,
  input  logic             res,
  input  nco_ctl_t         ctl,
  input  logic [ACC_W-1:0] word,
  output logic [ACC_W-1:0] inc_q,
  output logic [AMP_W-1:0] amp_q,
  output logic             am_q
);

  logic [ACC_W-1:0] inc_d;

  always_comb begin
    inc_d = inc_q;
    if (ctl.inc_full) begin
      inc_d = word;
    end else if (ctl.inc_coarse) begin
      inc_d = {word[COARSE_W-1:0], inc_q[FINE_W-1:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (res) begin
      inc_q <= '0;
      amp_q <= '0;
      am_q  <= 1'b0;
    end else begin
      inc_q <= inc_d;
      if (ctl.inc_coarse) amp_q <= word[ACC_W-1 -: AMP_W];
      if (ctl.load)       am_q  <= ctl.mode;
    end
  end

endmodule

// File: rtl/nco_accum.sv
module nco_accum
  import nco_pkg::*;
(
  input  logic             clk,
  input  logic             res,
  input  logic             abs_jump,
  input  logic [ACC_W-1:0] word,
  input  logic [ACC_W-1:0] inc,
  output logic [ACC_W-1:0] acc_q
);

  logic [ACC_W-1:0] sum;

  always_comb sum = acc_q + inc;

  always_ff @(posedge clk) begin
    if (res)           acc_q <= '0;
    else if (abs_jump) acc_q <= word;
    else               acc_q <= sum;
  end

endmodule

// File: rtl/nco_delay_line.sv
module nco_delay_line #(
  parameter int W     = 1,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         res,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (DEPTH == 0) begin : g_wire
      assign q = d;
    end else begin : g_regs
      logic [DEPTH-1:0][W-1:0] stg;
      always_ff @(posedge clk) begin
        if (res) begin
          stg <= '0;
        end else begin
          stg[0] <= d;
          for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
        end
      end
      assign q = stg[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/nco_phase_ctrl.sv
module nco_phase_ctrl
  import nco_pkg::*;
#(
  parameter int OUT_STAGES = 1
) (
  input  logic               clk,
  input  logic               res,
  input  logic               cen,
  input  logic               mode,
  input  logic               jump,
  input  logic [ACC_W-1:0]   din,
  input  logic               vin,
  output logic [PHASE_W-1:0] phase_o,
  output logic [AMP_W-1:0]   amp_o,
  output logic               am_en_o,
  output logic               vout
);

  localparam int LAT   = OUT_STAGES + 2;
  localparam int OUT_W = $bits(nco_out_t);

  nco_cmd_t         cmd_q;
  nco_ctl_t         ctl;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] inc_q;
  logic [AMP_W-1:0] amp_q;
  logic             am_q;
  nco_out_t         core_out;
  logic [OUT_W-1:0] pipe_q;
  nco_out_t         pipe_out;

  nco_capture i_capture (
    .clk   (clk),
    .res   (res),
    .cen   (cen),
    .mode  (mode),
    .jump  (jump),
    .din   (din),
    .cmd_q (cmd_q)
  );

  always_comb begin
    ctl.load       = cmd_q.load;
    ctl.mode       = cmd_q.mode;
    ctl.abs_jump   = cmd_q.load &  cmd_q.jump & ~cmd_q.mode;
    ctl.inc_full   = cmd_q.load & (cmd_q.mode ? cmd_q.jump : ~cmd_q.jump);
    ctl.inc_coarse = cmd_q.load &  cmd_q.mode & ~cmd_q.jump;
  end

  nco_incr_reg i_incr (
    .clk   (clk),
    .res   (res),
    .ctl   (ctl),
    .word  (cmd_q.word),
    .inc_q (inc_q),
    .amp_q (amp_q),
    .am_q  (am_q)
  );

  nco_accum i_accum (
    .clk      (clk),
    .res      (res),
    .abs_jump (ctl.abs_jump),
    .word     (cmd_q.word),
    .inc      (inc_q),
    .acc_q    (acc_q)
  );

  always_comb begin
    core_out.phase = acc_q[ACC_W-1 -: PHASE_W];
    core_out.amp   = amp_q;
    core_out.am_en = am_q;
  end

  nco_delay_line #(.W(OUT_W), .DEPTH(OUT_STAGES)) i_out_pipe (
    .clk (clk),
    .res (res),
    .d   (core_out),
    .q   (pipe_q)
  );

  nco_delay_line #(.W(1), .DEPTH(LAT)) i_vld_pipe (
    .clk (clk),
    .res (res),
    .d   (vin),
    .q   (vout)
  );

  always_comb begin
    pipe_out = nco_out_t'(pipe_q);
    phase_o  = pipe_out.phase;
    amp_o    = pipe_out.amp;
    am_en_o  = pipe_out.am_en;
  end

endmodule

// File: rtl/nco_phase_ctrl_chk.sv
module nco_phase_ctrl_chk
  import nco_pkg::*;
(
  input logic               clk,
  input logic               res,
  input logic               cen,
  input logic               vout,
  input logic [PHASE_W-1:0] phase_o,
  input nco_cmd_t           cmd_q,
  input logic [ACC_W-1:0]   acc_q,
  input logic [ACC_W-1:0]   inc_q
);

  AST_HOLD_WHEN_DISABLED: assert property (@(posedge clk) disable iff (res)
    cen |=> (cmd_q.word == $past(cmd_q.word))); // R1

  AST_ACC_ADVANCE: assert property (@(posedge clk) disable iff (res)
    !(cmd_q.load && cmd_q.jump && !cmd_q.mode) |=>
      (acc_q == ACC_W'($past(acc_q) + $past(inc_q)))); // R2

  AST_FULL_INC_MODE0: assert property (@(posedge clk) disable iff (res)
    (cmd_q.load && !cmd_q.jump && !cmd_q.mode) |=> (inc_q == $past(cmd_q.word))); // R3

  AST_ABS_JUMP: assert property (@(posedge clk) disable iff (res)
    (cmd_q.load && cmd_q.jump && !cmd_q.mode) |=>
      (acc_q == $past(cmd_q.word) && inc_q == $past(inc_q))); // R4

  AST_COARSE_KEEP_FINE: assert property (@(posedge clk) disable iff (res)
    (cmd_q.load && !cmd_q.jump && cmd_q.mode) |=>
      (inc_q == {$past(cmd_q.word[COARSE_W-1:0]), $past(inc_q[FINE_W-1:0])})); // R5

  AST_FULL_INC_MODE1: assert property (@(posedge clk) disable iff (res)
    (cmd_q.load && cmd_q.jump && cmd_q.mode) |=> (inc_q == $past(cmd_q.word))); // R6

  AST_JUMP_NEEDS_CAPTURE: assert property (@(posedge clk) disable iff (res)
    cen |=> (!cmd_q.load && !cmd_q.jump)); // R7

  AST_CLEAR_ALL: assert property (@(posedge clk)
    res |=> (acc_q == '0 && inc_q == '0 && phase_o == '0 && !vout)); // R8

endmodule

bind nco_phase_ctrl nco_phase_ctrl_chk i_chk (
  .clk     (clk),
  .res     (res),
  .cen     (cen),
  .vout    (vout),
  .phase_o (phase_o),
  .cmd_q   (cmd_q),
  .acc_q   (acc_q),
  .inc_q   (inc_q)
);

// File: tb/test_nco_phase_ctrl.sv
`timescale 1ns/1ps
module test_nco_phase_ctrl;

  logic        clk = 1'b0;
  logic        res = 1'b1;
  logic        cen = 1'b1;
  logic        mode = 1'b0;
  logic        jump = 1'b0;
  logic [33:0] din = '0;
  logic        vin = 1'b0;
  logic [15:0] phase_o;
  logic [15:0] amp_o;
  logic        am_en_o;
  logic        vout;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  nco_phase_ctrl i_nco_phase_ctrl (
    .clk     (clk),
    .res     (res),
    .cen     (cen),
    .mode    (mode),
    .jump    (jump),
    .din     (din),
    .vin     (vin),
    .phase_o (phase_o),
    .amp_o   (amp_o),
    .am_en_o (am_en_o),
    .vout    (vout)
  );

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string req, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset;
    res = 1'b1; cen = 1'b1; mode = 1'b0; jump = 1'b0; din = '0; vin = 1'b0;
    step(2);
    res = 1'b0;
  endtask

  task automatic t_reset_state;
    do_reset();
    chk("R8 phase after clear", 34'(phase_o), 34'h0);
    chk("R8 amp after clear", 34'(amp_o), 34'h0);
    chk("R8 am_en after clear", 34'(am_en_o), 34'h0);
    chk("R8 vout after clear", 34'(vout), 34'h0);
  endtask

  task automatic t_fixed_freq_wrap;
    do_reset();
    mode = 1'b0; jump = 1'b0; cen = 1'b0; din = 34'h3_0000_0000;
    step(1);
    cen = 1'b1; din = 34'h1_2345_6789;
    step(2);
    chk("R9 first phase", 34'(phase_o), 34'h0);
    step(1); chk("R2 R3 phase step 1", 34'(phase_o), 34'hC000);
    step(1); chk("R2 wrap step 2", 34'(phase_o), 34'h8000);
    din = 34'h0_0ABC_0000;
    step(1); chk("R1 held word step 3", 34'(phase_o), 34'h4000);
    step(1); chk("R2 full circle", 34'(phase_o), 34'h0);
    chk("R10 amp untouched in mode 0", 34'(amp_o), 34'h0);
  endtask

  task automatic t_abs_jump;
    do_reset();
    mode = 1'b0; jump = 1'b0; cen = 1'b0; din = 34'h0_0004_0000;
    step(1);
    jump = 1'b1; din = 34'h2_0000_0000;
    step(1);
    cen = 1'b1; jump = 1'b0; din = '0;
    step(1); chk("R9 before jump visible", 34'(phase_o), 34'h0);
    step(1); chk("R4 jump to half turn", 34'(phase_o), 34'h8000);
    step(1); chk("R4 increment kept", 34'(phase_o), 34'h8001);
    jump = 1'b1; din = 34'h1_0000_0000;
    step(1);
    jump = 1'b0;
    step(2); chk("R7 jump without capture ignored", 34'(phase_o), 34'h8004);
  endtask

  task automatic t_amplitude_mode;
    do_reset();
    mode = 1'b1; jump = 1'b0; cen = 1'b0; din = {16'h7FFF, 18'h00400};
    step(1);
    cen = 1'b1; din = 34'h3_FFFF_FFFF;
    step(1);
    chk("R10 amp not early", 34'(amp_o), 34'h0);
    chk("R10 am_en not early", 34'(am_en_o), 34'h0);
    step(1);
    chk("R5 amp value", 34'(amp_o), 34'h7FFF);
    chk("R10 am_en aligned", 34'(am_en_o), 34'h1);
    chk("R9 phase aligned", 34'(phase_o), 34'h0);
    step(1); chk("R5 coarse increment", 34'(phase_o), 34'h0100);
    mode = 1'b0; cen = 1'b0; din = '0;
    step(1);
    cen = 1'b1;
    step(2);
    chk("R10 amp held by mode 0 word", 34'(amp_o), 34'h7FFF);
    chk("R10 am_en follows mode 0", 34'(am_en_o), 34'h0);
    chk("R3 phase before zero increment", 34'(phase_o), 34'h0400);
    step(1); chk("R3 zero increment holds phase", 34'(phase_o), 34'h0400);
  endtask

  task automatic t_full_then_split;
    do_reset();
    mode = 1'b1; jump = 1'b1; cen = 1'b0; din = 34'h0_0000_8000;
    step(1);
    jump = 1'b0; din = {16'h8001, 18'h00001};
    step(1);
    cen = 1'b1; din = '0;
    step(1);
    chk("R6 amp unchanged by full load", 34'(amp_o), 34'h0);
    step(11);
    chk("R5 R6 low increment bits kept", 34'(phase_o), 34'h3);
    chk("R5 negative amp", 34'(amp_o), 34'h8001);
    chk("R10 am_en in mode 1", 34'(am_en_o), 34'h1);
  endtask

  task automatic t_midrun_clear;
    mode = 1'b0; jump = 1'b0; cen = 1'b0; din = 34'h0_0100_0000;
    step(1);
    cen = 1'b1;
    step(4);
    res = 1'b1;
    step(1);
    res = 1'b0;
    chk("R8 phase cleared", 34'(phase_o), 34'h0);
    chk("R8 amp cleared", 34'(amp_o), 34'h0);
    step(5);
    chk("R8 increment cleared", 34'(phase_o), 34'h0);
  endtask

  task automatic t_valid_delay;
    do_reset();
    vin = 1'b1;
    step(1);
    vin = 1'b0;
    chk("R11 vout after edge 0", 34'(vout), 34'h0);
    step(1); chk("R11 vout after edge 1", 34'(vout), 34'h0);
    step(1); chk("R11 vout after edge 2", 34'(vout), 34'h1);
    step(1); chk("R11 vout after edge 3", 34'(vout), 34'h0);
    chk("R11 vin leaves phase alone", 34'(phase_o), 34'h0);
  endtask

  initial begin
    @(negedge clk);
    t_reset_state();
    t_fixed_freq_wrap();
    t_abs_jump();
    t_amplitude_mode();
    t_full_then_split();
    t_midrun_clear();
    t_valid_delay();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule